// File: doc/BRIEF.md
# RC6 Infrared Frame Decoder

This block turns the demodulated output of an infrared receiver module into decoded RC6 mode-0 style frames. The receiver line is active low: a low level is a mark (carrier present), a high level is a space. The line passes through a synchronizer and is sampled only on a sample-enable input, nominally a 100 kHz tick. The length of each run of equal samples is measured in ticks.

Each finished run is sorted into a width class of one, two, three or six base units T. A frame state machine first looks for the leader. It then breaks every later run into unit-long slots and checks the Manchester pairing slot by slot, shifting the captured bits into a register. At the last slot it publishes a 3-bit mode, an 8-bit control byte and an 8-bit info byte together with a one-cycle valid pulse. A malformed frame produces a one-cycle error pulse instead.

A host integrates the block by feeding it the system clock, a tick enable and the receiver pin. It then reads the three fields on the cycle the valid pulse is high, or any time after, since the fields are held until the next good frame.

Top module: `rc6_ir_decoder`

## Requirements
- R1: The input is active low (a low level is a mark). It is resynchronized and then sampled only on cycles where the sample enable is high. With the enable held low, no activity on the line produces a valid or an error pulse.
- R2: A run of w ticks belongs to class k (k = 1, 2, 3 or 6) when 0.75·k·T ≤ w ≤ 1.25·k·T, with T = UNIT_TICKS. Where two ranges overlap, the smaller class is taken. Runs off the nominal width but inside these windows decode normally.
- R3: A frame is armed only by a 6T mark followed by a 2T space. A mark of any other width seen while idle is ignored and raises no error.
- R4: The bit after the leader is a start bit that must be a logical 1. A start bit of 0 raises an error and yields no valid pulse.
- R5: Bits are Manchester coded, with mark-then-space meaning 1 and space-then-mark meaning 0. They arrive MSB first as 3 mode bits, then 8 control bits, then 8 info bits. They appear on `mode`, `control` and `info`.
- R6: Between the mode and control fields comes a toggle bit whose halves are 2T each. Its value is discarded, so frames that differ only in the toggle give identical outputs.
- R7: An error pulse is raised inside a frame by either of two faults: a run that fits no class of R2, or a bit whose two halves are not complementary (for the toggle bit, whose two 2T halves are not complementary).
- R8: If no edge arrives for more than 10T while a frame is in progress, an error pulse is raised and the machine returns to idle.
- R9: `frame_valid` and `frame_error` are each one clock cycle wide and are never high together. `mode`, `control` and `info` change only on the cycle `frame_valid` is high and read zero after reset.
- R10: After a valid frame, no new frame is accepted until the line has been a space for at least 6T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample enable, one cycle per sample period |
| ir_rx_n | input | 1 | Demodulated receiver output, active low |
| mode | output | MODE_BITS | Decoded mode field |
| control | output | CTRL_BITS | Decoded control field |
| info | output | INFO_BITS | Decoded info field |
| frame_valid | output | 1 | One-cycle pulse: a good frame was decoded |
| frame_error | output | 1 | One-cycle pulse: a frame was aborted |

## Verification
A wrong slot position or shift step appears within one frame time as a field value that differs from the transmitted bits. A wrong width classification shows either as a spurious error or as a frame that never produces a valid pulse. A stuck frame state shows up no later than 10T after the last edge, either as a missing error pulse on a broken frame or as frames that are silently dropped. A state machine that leaves the post-frame quiet phase too early or too late is visible on the very next frame: it either accepts a frame sent after only a 2T gap or rejects one sent after a 10T gap.

// File: rtl/rc6rx_pkg.sv
package rc6rx_pkg;

  // pulse width classes, in base units
  typedef enum logic [2:0] {
    WC_BAD = 3'd0,
    WC_1   = 3'd1,
    WC_2   = 3'd2,
    WC_3   = 3'd3,
    WC_6   = 3'd6
  } wclass_e;

  // what a unit-long slot of the frame means
  typedef enum logic [2:0] {
    ROLE_START,   // first half of the start bit: must be mark
    ROLE_CAP,     // first half of a data bit: captured
    ROLE_DIFF,    // must differ from the previous slot
    ROLE_SAME,    // must equal the previous slot (inside a double-width half)
    ROLE_SKIP     // first half of the toggle bit: not captured
  } role_e;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_LEAD_SPACE,
    FS_DATA,
    FS_QUIET
  } fstate_e;

  // Class a run of w ticks against base unit t with a +/-25 % window.
  // Smaller classes are tested first, so they win where windows overlap.
  function automatic wclass_e classify_width(input int unsigned w, input int unsigned t);
    if (w * 4 >= t * 3  && w * 4 <= t * 5)  return WC_1;
    if (w * 4 >= t * 6  && w * 4 <= t * 10) return WC_2;
    if (w * 4 >= t * 9  && w * 4 <= t * 15) return WC_3;
    if (w * 4 >= t * 18 && w * 4 <= t * 30) return WC_6;
    return WC_BAD;
  endfunction

  // Slot layout counted in base units from the start of the start bit:
  // start (2), mode bits (2 each), toggle (4), control and info bits (2 each).
  function automatic role_e slot_role(input int pos, input int mode_bits);
    int tog;
    tog = 2 + 2 * mode_bits;
    if (pos == 0)                        return ROLE_START;
    if (pos == tog)                      return ROLE_SKIP;
    if (pos == tog + 1 || pos == tog + 3) return ROLE_SAME;
    if (pos == tog + 2)                  return ROLE_DIFF;
    if (pos % 2 == 0)                    return ROLE_CAP;
    return ROLE_DIFF;
  endfunction

  // Index of the first half of the final data bit.
  function automatic int last_slot(input int data_bits);
    return 4 + 2 * data_bits;
  endfunction

endpackage

// File: rtl/rc6rx_sampler.sv
module rc6rx_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ir_rx_n,
  output logic mark_sync
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], ~ir_rx_n};
  end

  assign mark_sync = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/rc6rx_runmeter.sv
module rc6rx_runmeter #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_en,
  input  logic          mark_sync,
  output logic          ev_stb,
  output logic          ev_lvl,
  output logic [CW-1:0] ev_w,
  output logic          cur_lvl,
  output logic [CW-1:0] run_len
);
  logic          smp_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= 1'b0;
      run_q  <= '0;
      ev_stb <= 1'b0;
      ev_lvl <= 1'b0;
      ev_w   <= '0;
    end else begin
      ev_stb <= 1'b0;
      if (smp_en) begin
        if (mark_sync != smp_q) begin
          ev_stb <= 1'b1;
          ev_lvl <= smp_q;
          ev_w   <= run_q;
          smp_q  <= mark_sync;
          run_q  <= CW'(1);
        end else if (run_q != '1) begin
          run_q <= run_q + CW'(1);
        end
      end
    end
  end

  assign cur_lvl = smp_q;
  assign run_len = run_q;
endmodule

// File: rtl/rc6rx_framer.sv
module rc6rx_framer
  import rc6rx_pkg::*;
#(
  parameter int UNIT_TICKS  = 44,
  parameter int MODE_BITS   = 3,
  parameter int CTRL_BITS   = 8,
  parameter int INFO_BITS   = 8,
  parameter int GAP_UNITS   = 10,
  parameter int QUIET_UNITS = 6,
  parameter int CW          = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ev_stb,
  input  logic                 ev_lvl,
  input  logic [CW-1:0]        ev_w,
  input  logic                 cur_lvl,
  input  logic [CW-1:0]        run_len,
  output logic [MODE_BITS-1:0] mode_o,
  output logic [CTRL_BITS-1:0] ctrl_o,
  output logic [INFO_BITS-1:0] info_o,
  output logic                 valid_o,
  output logic                 error_o,
  output logic                 busy_o,
  output logic                 feed_idle_o
);
  localparam int DATA_BITS   = MODE_BITS + CTRL_BITS + INFO_BITS;
  localparam int LAST_POS    = last_slot(DATA_BITS);
  localparam int POS_W       = $clog2(LAST_POS + 2);
  localparam int GAP_TICKS   = GAP_UNITS * UNIT_TICKS;
  localparam int QUIET_TICKS = QUIET_UNITS * UNIT_TICKS;
  localparam logic [POS_W-1:0] LAST_P  = POS_W'(LAST_POS);
  localparam logic [CW-1:0]    GAP_L   = CW'(GAP_TICKS);
  localparam logic [CW-1:0]    QUIET_L = CW'(QUIET_TICKS);

  fstate_e              st;
  logic [POS_W-1:0]     pos;
  logic [1:0]           rem;
  logic                 flvl;
  logic                 prev;
  logic [DATA_BITS-1:0] sr;

  wclass_e              wc;
  role_e                role;
  logic                 unit_ok;
  logic                 consume;
  logic                 last_unit;
  logic                 timeout;
  logic [DATA_BITS-1:0] sr_next;

  assign wc      = classify_width(32'(ev_w), UNIT_TICKS);
  assign role    = slot_role(int'(pos), MODE_BITS);
  assign consume = (st == FS_DATA) && (rem != 2'd0);
  assign sr_next = {sr[DATA_BITS-2:0], flvl};

  always_comb begin
    case (role)
      ROLE_START: unit_ok = flvl;
      ROLE_DIFF:  unit_ok = (flvl != prev);
      ROLE_SAME:  unit_ok = (flvl == prev);
      default:    unit_ok = 1'b1;
    endcase
  end

  assign last_unit = consume && unit_ok && (pos == LAST_P) && (rem == 2'd1);
  assign timeout   = ((st == FS_LEAD_SPACE) || ((st == FS_DATA) && (rem == 2'd0)))
                     && (run_len > GAP_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= FS_IDLE;
      pos     <= '0;
      rem     <= 2'd0;
      flvl    <= 1'b0;
      prev    <= 1'b0;
      sr      <= '0;
      mode_o  <= '0;
      ctrl_o  <= '0;
      info_o  <= '0;
      valid_o <= 1'b0;
      error_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      error_o <= 1'b0;
      case (st)
        FS_IDLE: begin
          if (ev_stb && ev_lvl && wc == WC_6) st <= FS_LEAD_SPACE;
        end
        FS_LEAD_SPACE: begin
          if (timeout) begin
            error_o <= 1'b1;
            st      <= FS_IDLE;
          end else if (ev_stb) begin
            if (!ev_lvl && wc == WC_2) begin
              st  <= FS_DATA;
              pos <= '0;
              rem <= 2'd0;
            end else begin
              error_o <= 1'b1;
              st      <= FS_IDLE;
            end
          end
        end
        FS_DATA: begin
          if (consume) begin
            if (!unit_ok) begin
              error_o <= 1'b1;
              rem     <= 2'd0;
              st      <= FS_IDLE;
            end else begin
              prev <= flvl;
              pos  <= pos + POS_W'(1);
              rem  <= rem - 2'd1;
              if (role == ROLE_CAP) sr <= sr_next;
              if (last_unit) begin
                valid_o <= 1'b1;
                mode_o  <= sr_next[DATA_BITS-1 -: MODE_BITS];
                ctrl_o  <= sr_next[CTRL_BITS+INFO_BITS-1 -: CTRL_BITS];
                info_o  <= sr_next[INFO_BITS-1:0];
                rem     <= 2'd0;
                st      <= FS_QUIET;
              end
            end
          end else if (timeout) begin
            error_o <= 1'b1;
            st      <= FS_IDLE;
          end else if (ev_stb) begin
            flvl <= ev_lvl;
            case (wc)
              WC_1: rem <= 2'd1;
              WC_2: rem <= 2'd2;
              WC_3: rem <= 2'd3;
              default: begin
                error_o <= 1'b1;
                st      <= FS_IDLE;
              end
            endcase
          end
        end
        FS_QUIET: begin
          if (!cur_lvl && run_len >= QUIET_L) st <= FS_IDLE;
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  assign busy_o      = (st == FS_LEAD_SPACE) || (st == FS_DATA);
  assign feed_idle_o = (rem == 2'd0);
endmodule

// File: rtl/rc6_ir_decoder.sv
module rc6_ir_decoder #(
  parameter int UNIT_TICKS  = 44,
  parameter int MODE_BITS   = 3,
  parameter int CTRL_BITS   = 8,
  parameter int INFO_BITS   = 8,
  parameter int GAP_UNITS   = 10,
  parameter int QUIET_UNITS = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_en,
  input  logic                 ir_rx_n,
  output logic [MODE_BITS-1:0] mode,
  output logic [CTRL_BITS-1:0] control,
  output logic [INFO_BITS-1:0] info,
  output logic                 frame_valid,
  output logic                 frame_error
);
  localparam int CW = $clog2(GAP_UNITS * UNIT_TICKS + 2);

  logic          mark_sync;
  logic          ev_stb;
  logic          ev_lvl;
  logic [CW-1:0] ev_w;
  logic          cur_lvl;
  logic [CW-1:0] run_len;
  logic          frame_busy;
  logic          feed_idle;

  rc6rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk       (clk),
    .rst       (rst),
    .ir_rx_n   (ir_rx_n),
    .mark_sync (mark_sync)
  );

  rc6rx_runmeter #(.CW(CW)) u_run (
    .clk       (clk),
    .rst       (rst),
    .smp_en    (smp_en),
    .mark_sync (mark_sync),
    .ev_stb    (ev_stb),
    .ev_lvl    (ev_lvl),
    .ev_w      (ev_w),
    .cur_lvl   (cur_lvl),
    .run_len   (run_len)
  );

  rc6rx_framer #(
    .UNIT_TICKS  (UNIT_TICKS),
    .MODE_BITS   (MODE_BITS),
    .CTRL_BITS   (CTRL_BITS),
    .INFO_BITS   (INFO_BITS),
    .GAP_UNITS   (GAP_UNITS),
    .QUIET_UNITS (QUIET_UNITS),
    .CW          (CW)
  ) u_frm (
    .clk         (clk),
    .rst         (rst),
    .ev_stb      (ev_stb),
    .ev_lvl      (ev_lvl),
    .ev_w        (ev_w),
    .cur_lvl     (cur_lvl),
    .run_len     (run_len),
    .mode_o      (mode),
    .ctrl_o      (control),
    .info_o      (info),
    .valid_o     (frame_valid),
    .error_o     (frame_error),
    .busy_o      (frame_busy),
    .feed_idle_o (feed_idle)
  );
endmodule

// File: rtl/rc6rx_chk.sv
module rc6rx_chk #(
  parameter int MODE_BITS = 3,
  parameter int CTRL_BITS = 8,
  parameter int INFO_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 valid,
  input logic                 error,
  input logic [MODE_BITS-1:0] mode,
  input logic [CTRL_BITS-1:0] control,
  input logic [INFO_BITS-1:0] info,
  input logic                 ev_stb,
  input logic                 feed_idle,
  input logic                 busy
);
  p_valid_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  p_error_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    error |=> !error);

  p_valid_error_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(valid && error));

  p_fields_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable({mode, control, info}) |-> valid);

  // an edge event never arrives while slots of the previous run are still pending
  p_event_feed_idle_r7: assert property (@(posedge clk) disable iff (rst)
    ev_stb |-> feed_idle);

  // errors only come from a frame in progress (leader space or data)
  p_error_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
    error |-> $past(busy));

  p_quiet_after_valid_r10: assert property (@(posedge clk) disable iff (rst)
    valid |=> !busy);
endmodule

bind rc6_ir_decoder rc6rx_chk #(
  .MODE_BITS (MODE_BITS),
  .CTRL_BITS (CTRL_BITS),
  .INFO_BITS (INFO_BITS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid     (frame_valid),
  .error     (frame_error),
  .mode      (mode),
  .control   (control),
  .info      (info),
  .ev_stb    (ev_stb),
  .feed_idle (feed_idle),
  .busy      (frame_busy)
);

// File: tb/sim_rc6_ir_decoder.sv
module sim_rc6_ir_decoder;
  localparam int T = 8;   // small base unit: 8 ticks, tick every 2 clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_en = 1'b0;
  logic       ir_rx_n = 1'b1;
  logic [2:0] mode;
  logic [7:0] control;
  logic [7:0] info;
  logic       frame_valid;
  logic       frame_error;

  rc6_ir_decoder #(.UNIT_TICKS(T)) u0 (
    .clk         (clk),
    .rst         (rst),
    .smp_en      (smp_en),
    .ir_rx_n     (ir_rx_n),
    .mode        (mode),
    .control     (control),
    .info        (info),
    .frame_valid (frame_valid),
    .frame_error (frame_error)
  );

  always #2 clk = ~clk;

  logic tick_on = 1'b1;
  always @(negedge clk) smp_en <= tick_on ? ~smp_en : 1'b0;

  int n_checks = 0, n_fail = 0;
  int vcnt = 0, ecnt = 0, vlong = 0, elong = 0;
  logic vprev = 1'b0, eprev = 1'b0;
  logic [2:0] cap_m = '0;
  logic [7:0] cap_c = '0, cap_i = '0;
  int cyc = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (frame_valid) begin
        vcnt++;
        cap_m = mode; cap_c = control; cap_i = info;
      end
      if (frame_error) ecnt++;
      if (frame_valid && vprev) vlong++;
      if (frame_error && eprev) elong++;
      if (frame_valid && frame_error) vlong++;
    end
    vprev = frame_valid;
    eprev = frame_error;
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, 190000);
      summary();
    end
  end

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- line driver ----------------
  logic run_l = 1'b0;
  int   run_n = 0;
  int   jit   = 0;

  task automatic hold(input logic lvl, input int ticks);
    ir_rx_n = ~lvl;
    repeat (ticks * 2) @(negedge clk);
  endtask

  task automatic flush();
    if (run_n > 0) hold(run_l, run_n * T + jit);
    run_n = 0;
  endtask

  task automatic put(input logic l, input int n);
    if (l == run_l) run_n += n;
    else begin
      flush();
      run_l = l;
      run_n = n;
    end
  endtask

  task automatic send_frame(input int lead, input logic [2:0] m, input logic t,
                            input logic [7:0] c, input logic [7:0] i,
                            input logic sb, input int gap);
    run_l = 1'b0; run_n = 0;
    put(1'b1, lead); put(1'b0, 2);
    put(sb, 1); put(~sb, 1);
    for (int b = 2; b >= 0; b--) begin put(m[b], 1); put(~m[b], 1); end
    put(t, 2); put(~t, 2);
    for (int b = 7; b >= 0; b--) begin put(c[b], 1); put(~c[b], 1); end
    for (int b = 7; b >= 0; b--) begin put(i[b], 1); put(~i[b], 1); end
    flush();
    hold(1'b0, gap * T);
  endtask

  task automatic expect_result(input string req, input int v0, input int e0,
                               input int ev, input int ee,
                               input logic [2:0] m, input logic [7:0] c, input logic [7:0] i);
    check((vcnt - v0) == ev, req, "valid count", vcnt - v0, ev);
    check((ecnt - e0) == ee, req, "error count", ecnt - e0, ee);
    if (ev > 0) begin
      check(cap_m == m, req, "mode", int'(cap_m), int'(m));
      check(cap_c == c, req, "control", int'(cap_c), int'(c));
      check(cap_i == i, req, "info", int'(cap_i), int'(i));
    end
  endtask

  initial begin
    int v0, e0;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R9: reset state
    check(frame_valid == 1'b0, "R9", "valid after reset", int'(frame_valid), 0);
    check(frame_error == 1'b0, "R9", "error after reset", int'(frame_error), 0);
    check({mode, control, info} == 19'd0, "R9", "fields after reset",
          int'({mode, control, info}), 0);

    // R5 / R1: sweep all mode values, active-low line, toggle alternating
    for (int m = 0; m < 8; m++) begin
      logic [7:0] c, i;
      c = 8'((m * 37) ^ 8'hA5);
      i = 8'((m * 29) + 7);
      v0 = vcnt; e0 = ecnt;
      send_frame(6, 3'(m), m[0], c, i, 1'b1, 10);
      expect_result("R5", v0, e0, 1, 0, 3'(m), c, i);
    end

    // R5: walking-one / walking-zero bit positions
    for (int k = 0; k < 8; k++) begin
      logic [7:0] c, i;
      c = 8'(1 << k);
      i = ~c;
      v0 = vcnt; e0 = ecnt;
      send_frame(6, 3'(7 - k), 1'b0, c, i, 1'b1, 10);
      expect_result("R5", v0, e0, 1, 0, 3'(7 - k), c, i);
    end

    // R6: toggle value has no effect on the fields
    v0 = vcnt; e0 = ecnt;
    send_frame(6, 3'd5, 1'b0, 8'h3C, 8'hC3, 1'b1, 10);
    expect_result("R6", v0, e0, 1, 0, 3'd5, 8'h3C, 8'hC3);
    v0 = vcnt; e0 = ecnt;
    send_frame(6, 3'd5, 1'b1, 8'h3C, 8'hC3, 1'b1, 10);
    expect_result("R6", v0, e0, 1, 0, 3'd5, 8'h3C, 8'hC3);

    // R2: every run stretched by +2 ticks, then shortened by 1 tick
    jit = 2;
    v0 = vcnt; e0 = ecnt;
    send_frame(6, 3'd2, 1'b1, 8'h00, 8'hFF, 1'b1, 10);
    expect_result("R2", v0, e0, 1, 0, 3'd2, 8'h00, 8'hFF);
    jit = -1;
    v0 = vcnt; e0 = ecnt;
    send_frame(6, 3'd6, 1'b0, 8'h55, 8'hAA, 1'b1, 10);
    expect_result("R2", v0, e0, 1, 0, 3'd6, 8'h55, 8'hAA);
    jit = 0;

    // R4: start bit 0 aborts the frame
    v0 = vcnt; e0 = ecnt;
    send_frame(6, 3'd1, 1'b0, 8'h12, 8'h34, 1'b0, 10);
    expect_result("R4", v0, e0, 0, 1, 3'd0, 8'h00, 8'h00);

    // R3: a 4T leader mark is ignored without error
    v0 = vcnt; e0 = ecnt;
    send_frame(4, 3'd3, 1'b0, 8'h12, 8'h34, 1'b1, 10);
    expect_result("R3", v0, e0, 0, 0, 3'd0, 8'h00, 8'h00);

    // R7: 4T mark inside a frame fits no class
    v0 = vcnt; e0 = ecnt;
    run_l = 1'b0; run_n = 0;
    put(1'b1, 6); put(1'b0, 2); put(1'b1, 1); put(1'b0, 1); put(1'b1, 4); put(1'b0, 10);
    flush();
    expect_result("R7", v0, e0, 0, 1, 3'd0, 8'h00, 8'h00);

    // R7: a mode bit with both halves mark breaks the Manchester pairing
    v0 = vcnt; e0 = ecnt;
    run_l = 1'b0; run_n = 0;
    put(1'b1, 6); put(1'b0, 2); put(1'b1, 1); put(1'b0, 1); put(1'b1, 2); put(1'b0, 10);
    flush();
    expect_result("R7", v0, e0, 0, 1, 3'd0, 8'h00, 8'h00);

    // R8: 12T silence after the start bit
    v0 = vcnt; e0 = ecnt;
    run_l = 1'b0; run_n = 0;
    put(1'b1, 6); put(1'b0, 2); put(1'b1, 1); put(1'b0, 12);
    flush();
    expect_result("R8", v0, e0, 0, 1, 3'd0, 8'h00, 8'h00);

    // R10: second frame after only a 2T gap is dropped, a later one decodes
    v0 = vcnt; e0 = ecnt;
    send_frame(6, 3'd4, 1'b0, 8'hDE, 8'hAD, 1'b1, 2);
    send_frame(6, 3'd1, 1'b1, 8'hBE, 8'hEF, 1'b1, 10);
    expect_result("R10", v0, e0, 1, 0, 3'd4, 8'hDE, 8'hAD);
    v0 = vcnt; e0 = ecnt;
    send_frame(6, 3'd7, 1'b0, 8'h81, 8'h18, 1'b1, 10);
    expect_result("R10", v0, e0, 1, 0, 3'd7, 8'h81, 8'h18);

    // R1: line activity with the sample enable held low is not seen
    tick_on = 1'b0;
    repeat (2) @(negedge clk);
    v0 = vcnt; e0 = ecnt;
    send_frame(6, 3'd3, 1'b0, 8'h66, 8'h99, 1'b1, 10);
    tick_on = 1'b1;
    repeat (20 * T) @(negedge clk);
    expect_result("R1", v0, e0, 0, 0, 3'd0, 8'h00, 8'h00);
    check({mode, control, info} == {3'd7, 8'h81, 8'h18}, "R9", "fields held",
          int'({mode, control, info}), int'({3'd7, 8'h81, 8'h18}));

    // R9: every pulse seen was exactly one cycle wide and never overlapped
    check(vlong == 0, "R9", "long or overlapping valid", vlong, 0);
    check(elong == 0, "R9", "long error", elong, 0);

    summary();
  end
endmodule